// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block tracks instructions from the point where they are dispatched until they retire. It is a circular buffer with one slot for each instruction in flight. Dispatch writes at most one new slot per cycle, in program order, and gets back a slot tag. Execution units then report finished results by that tag, in any order. The buffer releases slots one per cycle, and only from the oldest end. A slot leaves only once its result has arrived. The commit port then shows the slot's destination register and result. This is the only place where a result may update architectural state.

When a branch turns out to be mispredicted, the owner raises a flush with the tag of the mispredicted instruction. Every slot younger than that tag is discarded. The mispredicted instruction and everything older stay and retire normally. The flush tag must name a slot that currently holds an instruction. Flags and a count report how full the buffer is.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `count_o`=0, `commit_valid_o`=0, `alloc_ready_o`=1 and `alloc_tag_o`=0.
- R2: Accepted allocations receive consecutive tags in program order. Each tag equals the slot index, which advances by one and wraps from DEPTH-1 to 0.
- R3: With DEPTH (16) slots occupied, `full_o`=1 and `alloc_ready_o`=0. An allocation request in that state is refused, and both `alloc_tag_o` and `count_o` stay unchanged.
- R4: Slots retire strictly in allocation order, whatever order their completions arrive in, and every surviving slot retires exactly once.
- R5: While `commit_valid_o`=1, the commit port shows the tag of the oldest slot, the destination given at its allocation and the data from its completion report. The slot retires at that clock edge.
- R6: `commit_valid_o` stays 0 while the oldest slot has not completed, even if younger slots have completed.
- R7: A flush with tag T discards all slots younger than T. In the next cycle `alloc_tag_o`=T+1 (mod DEPTH), and `count_o` equals the number of slots from the oldest through T.
- R8: A completion report whose tag names an empty or already discarded slot is ignored. A slot allocated later at that index waits for its own completion before retiring.
- R9: When an allocation and a retirement happen in the same cycle with no flush, `count_o` is the same in the next cycle.
- R10: While the buffer is empty, `commit_valid_o`=0.
- R11: During a flush cycle `alloc_ready_o`=0, so the flush takes priority over a concurrent allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch requests a slot |
| alloc_dest_i | input | 5 | Architectural destination register of the new instruction |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_tag_o | output | 4 | Tag given to the next allocated slot |
| cmpl_valid_i | input | 1 | An execution unit reports a result |
| cmpl_tag_i | input | 4 | Tag of the finished slot |
| cmpl_data_i | input | 32 | Result value |
| flush_valid_i | input | 1 | Misprediction flush request |
| flush_tag_i | input | 4 | Tag of the mispredicted instruction; younger slots are discarded |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_tag_o | output | 4 | Tag of the retiring slot |
| commit_dest_o | output | 5 | Destination register of the retiring slot |
| commit_data_o | output | 32 | Result of the retiring slot |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| count_o | output | 5 | Number of occupied slots |

## Verification
The embedded properties check the following on every cycle:
- the occupancy bound;
- that a retirement only happens on a completed oldest slot;
- that the buffer stays idle while empty;
- that the flush blocks allocation and places the tail just after the flush tag;
- that the count stays stable when an allocation and a retirement pair up;
- that stale completions cannot mark a slot done.

Some properties only show up across a run, so the bench's scenarios demonstrate them:
- that retirement order follows allocation order under scrambled completion orders;
- that the dest and data pairing survives pointer wrap;
- that discarded slots never reach the commit port.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int unsigned ROB_DEPTH  = 16;
  parameter int unsigned ROB_ARCH_W = 5;
  parameter int unsigned ROB_DATA_W = 32;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = rob_pkg::ROB_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             commit_fire_i,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] flush_tag_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic [IDX_W-1:0] keep_dist_o,
  output logic [PTR_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] head_q, tail_q;

  // distance of the flush tag from the oldest slot; it and older survive
  assign keep_dist_o = flush_tag_i - head_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (commit_fire_i) head_q <= head_q + 1'b1;
      if (flush_i)           tail_q <= head_q + PTR_W'(keep_dist_o) + 1'b1;
      else if (alloc_fire_i) tail_q <= tail_q + 1'b1;
    end
  end

  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign count_o    = tail_q - head_q;
  assign full_o     = (count_o == PTR_W'(DEPTH));
  assign empty_o    = (count_o == '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= PTR_W'(DEPTH));
  p_full_no_alloc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_fire_i);
  p_flush_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> tail_idx_o == IDX_W'($past(flush_tag_i) + 1'b1));
  p_pair_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_fire_i && commit_fire_i && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int unsigned DEPTH  = rob_pkg::ROB_DEPTH,
  parameter int unsigned ARCH_W = rob_pkg::ROB_ARCH_W,
  parameter int unsigned DATA_W = rob_pkg::ROB_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_fire_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [ARCH_W-1:0] alloc_dest_i,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              commit_fire_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  keep_dist_i,
  output logic              head_ready_o,
  output logic [ARCH_W-1:0] head_dest_o,
  output logic [DATA_W-1:0] head_data_o
);
  logic [DEPTH-1:0]  valid_q, done_q, kill;
  logic [ARCH_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              cmpl_hit;

  // slots whose age exceeds the kept distance are speculative and die
  for (genvar g = 0; g < DEPTH; g++) begin : g_kill
    logic [IDX_W-1:0] age;
    assign age     = IDX_W'(g) - head_idx_i;
    assign kill[g] = flush_i && (age > keep_dist_i);
  end

  assign cmpl_hit = cmpl_valid_i && valid_q[cmpl_tag_i] && !kill[cmpl_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i]) begin
          valid_q[i] <= 1'b0;
          done_q[i]  <= 1'b0;
        end else if (alloc_fire_i && alloc_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
        end else if (commit_fire_i && head_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
          done_q[i]  <= 1'b0;
        end else if (cmpl_hit && cmpl_tag_i == IDX_W'(i)) begin
          done_q[i]  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_fire_i) dest_q[alloc_idx_i] <= alloc_dest_i;
    if (cmpl_hit)     data_q[cmpl_tag_i]  <= cmpl_data_i;
  end

  assign head_ready_o = valid_q[head_idx_i] && done_q[head_idx_i];
  assign head_dest_o  = dest_q[head_idx_i];
  assign head_data_o  = data_q[head_idx_i];

  p_retire_oldest_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_fire_i |-> (valid_q[head_idx_i] && done_q[head_idx_i]));
  p_stale_cmpl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && !valid_q[cmpl_tag_i]) |=> !done_q[$past(cmpl_tag_i)]);
  p_done_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q & ~valid_q) == '0);
endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int unsigned DEPTH  = rob_pkg::ROB_DEPTH,
  parameter int unsigned ARCH_W = rob_pkg::ROB_ARCH_W,
  parameter int unsigned DATA_W = rob_pkg::ROB_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [ARCH_W-1:0] alloc_dest_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_tag_o,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              flush_valid_i,
  input  logic [IDX_W-1:0]  flush_tag_i,
  output logic              commit_valid_o,
  output logic [IDX_W-1:0]  commit_tag_o,
  output logic [ARCH_W-1:0] commit_dest_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             alloc_fire, head_ready;
  logic [IDX_W-1:0] head_idx, tail_idx, keep_dist;

  assign alloc_ready_o  = !full_o && !flush_valid_i;
  assign alloc_fire     = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o    = tail_idx;
  assign commit_valid_o = head_ready;
  assign commit_tag_o   = head_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_fire_i(alloc_fire), .commit_fire_i(head_ready),
    .flush_i(flush_valid_i), .flush_tag_i(flush_tag_i),
    .head_idx_o(head_idx), .tail_idx_o(tail_idx), .keep_dist_o(keep_dist),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o)
  );

  rob_entries #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .DATA_W(DATA_W)) u_entries (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_fire_i(alloc_fire), .alloc_idx_i(tail_idx), .alloc_dest_i(alloc_dest_i),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_tag_i(cmpl_tag_i), .cmpl_data_i(cmpl_data_i),
    .commit_fire_i(head_ready), .head_idx_i(head_idx),
    .flush_i(flush_valid_i), .keep_dist_i(keep_dist),
    .head_ready_o(head_ready), .head_dest_o(commit_dest_o), .head_data_o(commit_data_o)
  );

  p_empty_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !commit_valid_o);
  p_flush_blocks_alloc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i |-> !alloc_ready_o);
endmodule

// File: tb/rob_top_bench.sv
`timescale 1ns/1ps
module rob_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        alloc_valid = 0, cmpl_valid = 0, flush_valid = 0;
  logic [4:0]  alloc_dest = 0;
  logic [3:0]  cmpl_tag = 0, flush_tag = 0;
  logic [31:0] cmpl_data = 0;
  logic        alloc_ready_o, commit_valid_o, full_o, empty_o;
  logic [3:0]  alloc_tag_o, commit_tag_o;
  logic [4:0]  commit_dest_o, count_o;
  logic [31:0] commit_data_o;

  rob_top u_rob_top (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_dest_i(alloc_dest),
    .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
    .cmpl_valid_i(cmpl_valid), .cmpl_tag_i(cmpl_tag), .cmpl_data_i(cmpl_data),
    .flush_valid_i(flush_valid), .flush_tag_i(flush_tag),
    .commit_valid_o(commit_valid_o), .commit_tag_o(commit_tag_o),
    .commit_dest_o(commit_dest_o), .commit_data_o(commit_data_o),
    .full_o(full_o), .empty_o(empty_o), .count_o(count_o)
  );

  int unsigned n_chk = 0, n_err = 0, n_commit = 0, n_expect = 0, seq = 0;
  bit          done_run = 0;
  logic [3:0]  exp_q[$];
  logic [4:0]  exp_dest [16];
  logic [31:0] exp_data [16];
  bit          exp_done [16];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor: each retirement must match the oldest expected slot
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && commit_valid_o) begin
        logic [3:0] t;
        n_commit++;
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected commit", commit_tag_o, 0);
        end else begin
          t = exp_q.pop_front();
          check(commit_tag_o == t, "R4 order", commit_tag_o, t);
          check(exp_done[t], "R6 retired before completion", 0, 1);
          check(commit_dest_o == exp_dest[t], "R5 dest", commit_dest_o, exp_dest[t]);
          check(commit_data_o == exp_data[t], "R5 data", commit_data_o, exp_data[t]);
          exp_done[t] = 0;
        end
      end
    end
  end

  task automatic do_alloc(input logic [4:0] d, output logic [3:0] tag);
    alloc_valid = 1; alloc_dest = d;
    @(negedge clk);
    tag = alloc_tag_o;
    if (alloc_ready_o) begin
      exp_q.push_back(alloc_tag_o);
      exp_dest[alloc_tag_o] = d;
      exp_done[alloc_tag_o] = 0;
      n_expect++;
    end
    step();
    alloc_valid = 0;
  endtask

  task automatic do_cmpl(input logic [3:0] t, input bit live);
    seq++;
    cmpl_valid = 1; cmpl_tag = t; cmpl_data = 32'hA500_0000 | seq;
    if (live) begin
      exp_data[t] = 32'hA500_0000 | seq;
      exp_done[t] = 1;
    end
    step();
    cmpl_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && !empty_o; i++) step();
  endtask

  initial begin
    logic [3:0] tg [16];
    logic [3:0] base, t;
    #(4 * 200000);
    if (!done_run) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] tg [16];
    logic [3:0] base, t;
    logic [4:0] c0;
    #9; rst_n = 1; step();
    // R1 reset state
    @(negedge clk);
    check(empty_o && !full_o && count_o == 0, "R1 flags", count_o, 0);
    check(!commit_valid_o && alloc_ready_o && alloc_tag_o == 0, "R1 ports", alloc_tag_o, 0);
    step();

    // R2 sequential tags; R6 younger completion does not retire; R4 scrambled completions
    for (int i = 0; i < 4; i++) begin
      do_alloc(5'(i + 3), tg[i]);
      check(tg[i] == 4'(i), "R2 tag", tg[i], i);
    end
    do_cmpl(tg[2], 1);
    step();
    @(negedge clk);
    check(!commit_valid_o, "R6 head not done", commit_valid_o, 0);
    step();
    do_cmpl(tg[3], 1);
    do_cmpl(tg[0], 1);
    do_cmpl(tg[1], 1);
    drain();
    @(negedge clk);
    check(empty_o && !commit_valid_o, "R10 empty idle", commit_valid_o, 0);
    step();

    // R3 fill with wrap, refuse extra, retire in order after reverse completion
    base = alloc_tag_o;
    for (int i = 0; i < 16; i++) do_alloc(5'(i), tg[i]);
    @(negedge clk);
    check(full_o && count_o == 16 && !alloc_ready_o, "R3 full", count_o, 16);
    step();
    do_alloc(5'd31, t);
    check(t == base, "R3 tag held", t, base);
    @(negedge clk);
    check(count_o == 16, "R3 count held", count_o, 16);
    step();
    for (int i = 15; i >= 0; i--) do_cmpl(tg[i], 1);
    drain();

    // R9 allocation paired with retirement
    do_alloc(5'd7, t);
    do_cmpl(t, 1);
    alloc_valid = 1; alloc_dest = 5'd9;
    @(negedge clk);
    c0 = count_o;
    check(commit_valid_o && c0 == 1, "R9 setup", c0, 1);
    exp_q.push_back(alloc_tag_o); exp_dest[alloc_tag_o] = 5'd9;
    exp_done[alloc_tag_o] = 0; n_expect++; t = alloc_tag_o;
    step();
    alloc_valid = 0;
    @(negedge clk);
    check(count_o == c0, "R9 count stable", count_o, c0);
    step();
    do_cmpl(t, 1);
    drain();

    // R7/R11 flush younger than the third of six
    for (int i = 0; i < 6; i++) do_alloc(5'(20 + i), tg[i]);
    flush_valid = 1; flush_tag = tg[2]; alloc_valid = 1; alloc_dest = 5'd1;
    @(negedge clk);
    check(!alloc_ready_o, "R11 flush blocks alloc", alloc_ready_o, 0);
    step();
    flush_valid = 0; alloc_valid = 0;
    for (int i = 0; i < 3; i++) begin
      void'(exp_q.pop_back());
      n_expect--;
    end
    @(negedge clk);
    check(alloc_tag_o == 4'(tg[2] + 1), "R7 tail after flush", alloc_tag_o, 4'(tg[2] + 1));
    check(count_o == 3, "R7 count after flush", count_o, 3);
    step();
    do_cmpl(tg[4], 0); // discarded slot
    do_cmpl(tg[0], 1);
    do_cmpl(tg[1], 1);
    do_cmpl(tg[2], 1);
    drain();
    // R8 stale completion into empty slot, then reuse of that index
    do_cmpl(tg[3], 0);
    do_alloc(5'd11, t);
    check(t == tg[3], "R8 reuse index", t, tg[3]);
    step(); step();
    @(negedge clk);
    check(!commit_valid_o && count_o == 1, "R8 stale ignored", commit_valid_o, 0);
    step();
    do_cmpl(t, 1);
    drain();
    step(); step();
    check(exp_q.size() == 0 && n_commit == n_expect, "R4 all retired once", n_commit, n_expect);

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule